// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block derives the 16x oversampling strobe for a UART receiver and transmitter from a fixed 48 MHz reference clock. Software supplies a divisor with a 14-bit whole part and a 3-bit part counted in eighths. The block produces a one-cycle tick on `tick_o` whose average spacing, in reference cycles, equals that divisor exactly. An eighths value of k is met by making k of every eight tick periods one reference cycle longer than the whole part. The long periods are spread as evenly as possible. With a 48 MHz reference, legal whole parts from 2 to 16383 give baud rates from about 183 baud up to 1.5 Mbaud.

Two small whole-part codes select faster rates, and for both the eighths field is ignored. Code 0 gives a tick on every reference cycle, which is 3 Mbaud. Code 1 gives periods that alternate between 1 and 2 cycles, which is 2 Mbaud.

A divisor is written by presenting it with a one-cycle load strobe. It is held as pending and takes effect only at the next tick boundary. The period in progress therefore always completes with its old length.

Top module: `frac_baud_tick`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is low. After reset the divisor is RST_INT with eighths RST_FRAC (default 26 and 0), and the first tick appears RST_INT-1 cycles after reset is released.
- R2: With eighths 0 and whole part n (2 to 16383), every tick period lasts exactly n reference cycles.
- R3: With whole part n of 2 or more and eighths k, any 8 consecutive tick periods after the divisor takes effect span exactly 8n+k reference cycles. Each single period lasts n or n+1 cycles.
- R4: Periods are numbered j = 0, 1, 2, ... from the first period that uses a new divisor. Period j lasts n+1 cycles exactly when floor((j+1)k/8) > floor(jk/8), and n cycles otherwise.
- R5: Whole-part code 0 makes `tick_o` high on every reference cycle, whatever the eighths field holds.
- R6: Whole-part code 1 makes the periods alternate 1, 2, 1, 2, ..., starting with 1, whatever the eighths field holds.
- R7: A load strobe in a cycle without a tick does not change the period in progress. The new divisor governs the periods that start from the next tick on.
- R8: A load strobe in the same cycle as a tick applies the new divisor to the period that starts at that tick.
- R9: When several loads arrive within one period, only the last one takes effect at the next tick.
- R10: For a whole part of 2 or more, `tick_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 48 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_int_i | input | 14 | Whole part of the divisor (0 and 1 are special codes) |
| div_frac_i | input | 3 | Eighths part of the divisor |
| div_load_i | input | 1 | One-cycle strobe that captures the divisor inputs |
| tick_o | output | 1 | One-cycle 16x oversampling tick |

## Verification
The hardest case to reach from the ports is a load that lands in exactly the cycle in which a tick is high. The outcome there is different from a load one cycle earlier or later. The random part of the bench places each load after a random number of idle cycles, with many short divisors, so that loads often coincide with ticks. A directed case also waits for a tick and strobes the load in that same cycle. Loads in the middle of a long period are exercised by a separate directed sequence, which also overwrites the pending divisor before the boundary.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    localparam int unsigned INT_W  = 14;
    localparam int unsigned FRAC_W = 3;
    localparam int unsigned PHASES = 1 << FRAC_W;

    typedef struct packed {
        logic [INT_W-1:0]  n;
        logic [FRAC_W-1:0] k;
    } div_t;

    // Map the raw software fields to an effective whole/eighths pair.
    function automatic div_t decode_div(logic [INT_W-1:0] raw_n, logic [FRAC_W-1:0] raw_k);
        div_t d;
        if (raw_n == '0) begin
            d.n = INT_W'(1);
            d.k = '0;
        end else if (raw_n == INT_W'(1)) begin
            d.n = INT_W'(1);
            d.k = FRAC_W'(PHASES / 2);
        end else begin
            d.n = raw_n;
            d.k = raw_k;
        end
        return d;
    endfunction

endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch
    import baud_tick_pkg::*;
#(
    parameter div_t RST_DIV = '{n: INT_W'(26), k: '0}
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [INT_W-1:0]  raw_n_i,
    input  logic [FRAC_W-1:0] raw_k_i,
    input  logic              tick_i,
    output div_t              nxt_div_o,
    output logic              restart_o,
    output div_t              act_div_o,
    output logic              pend_vld_o
);

    typedef struct packed {
        div_t act;
        div_t pend;
        logic pend_vld;
    } latch_st_t;

    latch_st_t st_d, st_q;
    div_t      in_div;
    div_t      cand;
    logic      apply;

    always_comb begin
        st_d   = st_q;
        in_div = decode_div(raw_n_i, raw_k_i);
        cand   = load_i ? in_div : st_q.pend;
        apply  = tick_i && (load_i || st_q.pend_vld);
        if (apply) begin
            st_d.act      = cand;
            st_d.pend_vld = 1'b0;
        end else if (load_i) begin
            st_d.pend     = in_div;
            st_d.pend_vld = 1'b1;
        end
        nxt_div_o  = apply ? cand : st_q.act;
        restart_o  = apply;
        act_div_o  = st_q.act;
        pend_vld_o = st_q.pend_vld;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.act      <= RST_DIV;
            st_q.pend     <= RST_DIV;
            st_q.pend_vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/baud_frac_seq.sv
module baud_frac_seq
    import baud_tick_pkg::*;
#(
    parameter logic [FRAC_W-1:0] RST_K = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              restart_i,
    input  logic [FRAC_W-1:0] k_i,
    output logic              long_o
);

    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } seq_st_t;

    seq_st_t           st_d, st_q;
    logic [FRAC_W-1:0] base;
    logic [FRAC_W:0]   sum;

    always_comb begin
        st_d   = st_q;
        base   = restart_i ? '0 : st_q.acc;
        sum    = {1'b0, base} + {1'b0, k_i};
        long_o = tick_i && sum[FRAC_W];
        if (tick_i) begin
            st_d.acc = sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.acc <= RST_K;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt
    import baud_tick_pkg::*;
#(
    parameter logic [INT_W-1:0] RST_N = INT_W'(26)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [INT_W-1:0] n_i,
    input  logic             long_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [INT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t        st_d, st_q;
    logic [INT_W:0] reload;

    always_comb begin
        st_d   = st_q;
        tick_o = (st_q.cnt == '0);
        reload = {1'b0, n_i} + {{INT_W{1'b0}}, long_i} - (INT_W+1)'(1);
        if (tick_o) begin
            st_d.cnt = reload[INT_W-1:0];
        end else begin
            st_d.cnt = st_q.cnt - INT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= RST_N - INT_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/frac_baud_tick.sv
module frac_baud_tick
    import baud_tick_pkg::*;
#(
    parameter int unsigned RST_INT  = 26,
    parameter int unsigned RST_FRAC = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [INT_W-1:0]  div_int_i,
    input  logic [FRAC_W-1:0] div_frac_i,
    input  logic              div_load_i,
    output logic              tick_o
);

    localparam div_t RST_EFF = decode_div(INT_W'(RST_INT), FRAC_W'(RST_FRAC));

    div_t nxt_div;
    div_t act_div;
    logic restart;
    logic pend_vld;
    logic long_per;

    baud_div_latch #(
        .RST_DIV (RST_EFF)
    ) latch_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (div_load_i),
        .raw_n_i    (div_int_i),
        .raw_k_i    (div_frac_i),
        .tick_i     (tick_o),
        .nxt_div_o  (nxt_div),
        .restart_o  (restart),
        .act_div_o  (act_div),
        .pend_vld_o (pend_vld)
    );

    baud_frac_seq #(
        .RST_K (RST_EFF.k)
    ) seq_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_o),
        .restart_i (restart),
        .k_i       (nxt_div.k),
        .long_o    (long_per)
    );

    baud_period_cnt #(
        .RST_N (RST_EFF.n)
    ) cnt_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .n_i    (nxt_div.n),
        .long_i (long_per),
        .tick_o (tick_o)
    );

endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk
    import baud_tick_pkg::*;
(
    input logic clk_i,
    input logic rst_ni,
    input logic tick_o,
    input logic div_load_i,
    input div_t act_div,
    input logic pend_vld
);

    logic [INT_W:0] len_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            len_q <= (INT_W+1)'(1);
        end else if (tick_o) begin
            len_q <= (INT_W+1)'(1);
        end else begin
            len_q <= len_q + (INT_W+1)'(1);
        end
    end

    // R3: a finished period lasts n or n+1 cycles of the divisor that governed it
    assert_period_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> ((len_q == {1'b0, act_div.n}) || (len_q == {1'b0, act_div.n} + (INT_W+1)'(1))));

    // R5: code 0 ticks every cycle
    assert_every_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_div.n == INT_W'(1) && act_div.k == '0) |-> tick_o);

    // R6: code 1 never leaves a gap longer than one cycle
    assert_short_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_div.n == INT_W'(1) && !tick_o) |=> tick_o);

    // R7: the active divisor only moves at a tick boundary
    assert_hold_div_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_o |=> $stable(act_div));

    // R9: a load away from a tick is kept pending
    assert_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_load_i && !tick_o) |=> pend_vld);

    // R9: the pending value is consumed at the tick boundary
    assert_consume_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && !div_load_i) |=> !pend_vld);

    // R10: single-cycle tick for whole parts of 2 or more
    assert_single_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (act_div.n == INT_W'(1) || !tick_o));

endmodule

bind frac_baud_tick baud_tick_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_o     (tick_o),
    .div_load_i (div_load_i),
    .act_div    (act_div),
    .pend_vld   (pend_vld)
);

// File: tb/frac_baud_tick_tb_top.sv
module frac_baud_tick_tb_top;

    localparam int RST_INT  = 26;
    localparam int MAXT     = 40;
    localparam int WD_LIMIT = 190000;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [13:0] div_int_i = '0;
    logic [2:0]  div_frac_i = '0;
    logic        div_load_i = 1'b0;
    logic        tick_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int tt [MAXT];

    frac_baud_tick #(.RST_INT(RST_INT), .RST_FRAC(0)) dut_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .div_int_i  (div_int_i),
        .div_frac_i (div_frac_i),
        .div_load_i (div_load_i),
        .tick_o     (tick_o)
    );

    always #2.5 clk_i = ~clk_i;
    always @(posedge clk_i) cyc <= cyc + 1;

    function automatic int eff_n(int iv);
        return (iv < 2) ? 1 : iv;
    endfunction

    function automatic int eff_k(int iv, int fv);
        if (iv == 0) return 0;
        if (iv == 1) return 4;
        return fv;
    endfunction

    function automatic int exp_per(int iv, int fv, int j);
        int n = eff_n(iv);
        int k = eff_k(iv, fv);
        return n + ((j + 1) * k) / 8 - (j * k) / 8;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge: strobes the load now and records nper+1 tick times.
    task automatic load_and_capture(input int iv, input int fv, input int nper, output int got);
        int guard = 0;
        got = 0;
        div_int_i  = 14'(iv);
        div_frac_i = 3'(fv);
        div_load_i = 1'b1;
        while (got < nper + 1 && guard < 60000) begin
            if (tick_o) begin
                tt[got] = cyc;
                got++;
            end
            if (got < nper + 1) begin
                @(negedge clk_i);
                div_load_i = 1'b0;
            end
            guard++;
        end
        chk(got == nper + 1, "R2 tick count", got, nper + 1);
    endtask

    task automatic check_periods(input int iv, input int fv, input int got, input string req);
        int n = eff_n(iv);
        int k = eff_k(iv, fv);
        for (int j = 0; j + 1 < got; j++) begin
            chk(tt[j+1] - tt[j] == exp_per(iv, fv, j), req, tt[j+1] - tt[j], exp_per(iv, fv, j));
        end
        for (int j = 0; j + 8 < got; j++) begin
            chk(tt[j+8] - tt[j] == 8 * n + k, "R3 window", tt[j+8] - tt[j], 8 * n + k);
        end
    endtask

    task automatic run_case(input int iv, input int fv, input int nper, input string req);
        int got;
        load_and_capture(iv, fv, nper, got);
        check_periods(iv, fv, got, req);
    endtask

    initial begin
        int c0;
        int got;
        int t_last;
        int iv;
        int fv;
        void'($urandom(32'd1234));

        // R1: reset state
        repeat (3) @(negedge clk_i);
        chk(tick_o == 1'b0, "R1 tick low in reset", tick_o, 0);
        rst_ni = 1'b1;
        c0 = cyc;
        while (!tick_o && cyc - c0 < 1000) @(negedge clk_i);
        chk(cyc - c0 == RST_INT - 1, "R1 first tick", cyc - c0, RST_INT - 1);

        // R2: plain integer divisors
        @(negedge clk_i);
        run_case(2, 0, 10, "R2 n=2");
        @(negedge clk_i);
        run_case(37, 0, 10, "R2 n=37");

        // R3/R4: each eighths value
        for (int k = 1; k < 8; k++) begin
            @(negedge clk_i);
            run_case(5, k, 17, "R4 pattern");
        end
        @(negedge clk_i);
        run_case(3000, 5, 9, "R3 large n");
        @(negedge clk_i);
        run_case(16383, 7, 1, "R2 max n");

        // R5 / R6: special codes, eighths ignored
        @(negedge clk_i);
        run_case(0, 6, 12, "R5 code 0");
        @(negedge clk_i);
        run_case(1, 7, 12, "R6 code 1");
        @(negedge clk_i);
        run_case(1, 0, 12, "R6 code 1 frac 0");

        // R7 / R9: loads in the middle of a long period
        @(negedge clk_i);
        load_and_capture(200, 0, 2, got);
        t_last = tt[got-1];
        repeat (50) @(negedge clk_i);
        div_int_i = 14'd7; div_frac_i = 3'd3; div_load_i = 1'b1;
        @(negedge clk_i);
        div_load_i = 1'b0;
        repeat (20) @(negedge clk_i);
        load_and_capture(5, 2, 9, got);
        chk(tt[0] - t_last == 200, "R7 old period kept", tt[0] - t_last, 200);
        check_periods(5, 2, got, "R9 last load wins");

        // R8: load in the very cycle of a tick
        @(negedge clk_i);
        while (!tick_o) @(negedge clk_i);
        c0 = cyc;
        load_and_capture(9, 4, 9, got);
        chk(tt[0] == c0, "R8 applies at same tick", tt[0], c0);
        check_periods(9, 4, got, "R8 periods");

        // Random mix
        for (int r = 0; r < 24; r++) begin
            iv = $urandom_range(0, 40);
            fv = $urandom_range(0, 7);
            repeat ($urandom_range(0, 30)) @(negedge clk_i);
            run_case(iv, fv, 16, "R4 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc >= WD_LIMIT);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule